// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

This block takes up to 64 device interrupt request lines and steers them to four processors. A single raw request register records which lines are pending and is shared by every processor. Each processor owns a 64-bit enable mask, and the block keeps a routed vector per processor equal to that mask ANDed with the raw requests. Each processor gets one level interrupt output, which is high while its routed vector holds any bit.

Hardware sources drive one set strobe and one clear strobe per line. Software reaches the block through a 64-bit register port that accepts one request per cycle and answers one cycle later. The routed vectors are recomputed whenever a mask is written or a raw request bit changes. A mask write therefore raises a processor's interrupt when it enables a pending line, and drops it when it disables the last routed line.

Top module: `dev_irq_router`

## Requirements
- R1: The register index is `req_addr >> 6`, so registers sit 64 bytes apart and address bits 5:0 are ignored. Index c (0..3) is the mask of CPU c. Index 4+c is the routed vector of CPU c. Index 8 is the raw request register.
- R2: `req_size` gives log2 of the access size in bytes. Only code 3 (8 bytes) is legal. Any other code makes the response carry `rsp_err`=1 and `rsp_rdata`=0, and changes no state.
- R3: A read of the routed vector of CPU c always returns mask[c] AND raw, using the values after all earlier updates.
- R4: A high `src_set[n]` sets raw bit n at the next clock edge. When `src_set[n]` and `src_clr[n]` are high in the same cycle, the set wins.
- R5: A high `src_clr[n]` clears raw bit n. Clearing a bit that is already clear changes nothing.
- R6: `cpu_irq[c]` is the OR of CPU c's routed vector, registered one cycle after that vector updates. A cause sampled at clock edge k therefore shows on `cpu_irq` after edge k+1.
- R7: A mask write that enables a pending line asserts that CPU's interrupt. A mask write that removes its last routed line deasserts it.
- R8: Writes to routed or raw indices and accesses to any index above 8 return `rsp_err`=1 and change no state.
- R9: Reset clears every mask, the raw register, every routed vector, `cpu_irq` and the response outputs.
- R10: Every request gets exactly one `rsp_valid` pulse in the following cycle. Legal reads carry the data. Writes and errored accesses return `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset from the block base |
| req_size | input | 2 | log2 of the access size in bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access error flag, qualified by rsp_valid |
| rsp_rdata | output | 64 | Read data |
| src_set | input | 64 | Per-line request set strobes |
| src_clr | input | 64 | Per-line request clear strobes |
| cpu_irq | output | 4 | Per-CPU level device interrupt |

## Verification
Single-line raises with disjoint and overlapping masks show whether each line is steered only to processors that enable it. A set and a clear on the same line in one cycle tests the priority between them. A clear of a line that is not pending tests that a spurious clear does nothing. Mask writes that enable an already pending line, and then take it away, show that mask writes alone move the outputs. A long run of sparse random strobes mixed with register traffic is compared every clock against a behavioural model, which exposes wrong latency or stale routed vectors.

// File: rtl/dev_irq_router_pkg.sv
package dev_irq_router_pkg;

    // log2(bytes) code of the only legal access size
    localparam logic [1:0] SIZE_8B = 2'd3;

    typedef enum logic [1:0] {
        KIND_MASK   = 2'd0,
        KIND_ROUTED = 2'd1,
        KIND_RAW    = 2'd2,
        KIND_NONE   = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/dev_irq_decode.sv
module dev_irq_decode
    import dev_irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = 6,
    localparam int CPU_IDX_W = $clog2(NUM_CPU)
) (
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [IDX_W-1:0]     req_idx,
    input  logic [1:0]           req_size,
    output reg_kind_e            kind,
    output logic [CPU_IDX_W-1:0] cpu,
    output logic                 acc_err,
    output logic                 mask_we
);

    logic size_ok;

    always_comb begin
        kind = KIND_NONE;
        cpu  = '0;
        if (req_idx < IDX_W'(NUM_CPU)) begin
            kind = KIND_MASK;
            cpu  = CPU_IDX_W'(req_idx);
        end else if (req_idx < IDX_W'(2 * NUM_CPU)) begin
            kind = KIND_ROUTED;
            cpu  = CPU_IDX_W'(req_idx - IDX_W'(NUM_CPU));
        end else if (req_idx == IDX_W'(2 * NUM_CPU)) begin
            kind = KIND_RAW;
        end

        size_ok = (req_size == SIZE_8B);
        // only the mask registers are writable
        acc_err = req_valid && (!size_ok || (kind == KIND_NONE) ||
                                (req_write && (kind != KIND_MASK)));
        mask_we = req_valid && req_write && size_ok && (kind == KIND_MASK);
    end

endmodule

// File: rtl/dev_irq_core.sv
module dev_irq_core #(
    parameter int NUM_CPU = 4,
    parameter int SRC_W   = 64,
    localparam int CPU_IDX_W = $clog2(NUM_CPU)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [SRC_W-1:0]                src_set,
    input  logic [SRC_W-1:0]                src_clr,
    input  logic                            mask_we,
    input  logic [CPU_IDX_W-1:0]            mask_cpu,
    input  logic [SRC_W-1:0]                mask_wdata,
    output logic [NUM_CPU-1:0][SRC_W-1:0]   mask_o,
    output logic [NUM_CPU-1:0][SRC_W-1:0]   routed_o,
    output logic [SRC_W-1:0]                raw_o,
    output logic [NUM_CPU-1:0]              irq_o
);

    typedef struct packed {
        logic [SRC_W-1:0]              raw;
        logic [NUM_CPU-1:0][SRC_W-1:0] mask;
        logic [NUM_CPU-1:0][SRC_W-1:0] routed;
        logic [NUM_CPU-1:0]            irq;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set has priority over clear on the same line
        st_d.raw = (st_q.raw & ~src_clr) | src_set;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (mask_we && (mask_cpu == CPU_IDX_W'(c))) begin
                st_d.mask[c] = mask_wdata;
            end
            // routed vector follows the updated mask and raw request
            st_d.routed[c] = st_d.mask[c] & st_d.raw;
            // output lags the routed vector by one register
            st_d.irq[c]    = |st_q.routed[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o   = st_q.mask;
    assign routed_o = st_q.routed;
    assign raw_o    = st_q.raw;
    assign irq_o    = st_q.irq;

endmodule

// File: rtl/dev_irq_router.sv
module dev_irq_router
    import dev_irq_router_pkg::*;
#(
    parameter int NUM_CPU    = 4,
    parameter int SRC_W      = 64,
    parameter int ADDR_W     = 12,
    parameter int REG_STRIDE = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic [SRC_W-1:0]   req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [SRC_W-1:0]   rsp_rdata,
    input  logic [SRC_W-1:0]   src_set,
    input  logic [SRC_W-1:0]   src_clr,
    output logic [NUM_CPU-1:0] cpu_irq
);

    localparam int IDX_LSB   = $clog2(REG_STRIDE);
    localparam int IDX_W     = ADDR_W - IDX_LSB;
    localparam int CPU_IDX_W = $clog2(NUM_CPU);

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [SRC_W-1:0] data;
    } rsp_state_t;

    reg_kind_e                     dec_kind;
    logic [CPU_IDX_W-1:0]          dec_cpu;
    logic                          dec_err;
    logic                          dec_mask_we;
    logic [NUM_CPU-1:0][SRC_W-1:0] mask_q;
    logic [NUM_CPU-1:0][SRC_W-1:0] routed_q;
    logic [SRC_W-1:0]              raw_q;
    logic [SRC_W-1:0]              rd_sel;
    logic                          addr_lo_unused;
    rsp_state_t                    rsp_d, rsp_q;

    // offset bits inside one register slot carry no meaning
    assign addr_lo_unused = ^req_addr[IDX_LSB-1:0];

    dev_irq_decode #(
        .NUM_CPU (NUM_CPU),
        .IDX_W   (IDX_W)
    ) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_idx   (req_addr[ADDR_W-1:IDX_LSB]),
        .req_size  (req_size),
        .kind      (dec_kind),
        .cpu       (dec_cpu),
        .acc_err   (dec_err),
        .mask_we   (dec_mask_we)
    );

    dev_irq_core #(
        .NUM_CPU (NUM_CPU),
        .SRC_W   (SRC_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_set    (src_set),
        .src_clr    (src_clr),
        .mask_we    (dec_mask_we),
        .mask_cpu   (dec_cpu),
        .mask_wdata (req_wdata),
        .mask_o     (mask_q),
        .routed_o   (routed_q),
        .raw_o      (raw_q),
        .irq_o      (cpu_irq)
    );

    always_comb begin
        unique case (dec_kind)
            KIND_MASK:   rd_sel = mask_q[dec_cpu];
            KIND_ROUTED: rd_sel = routed_q[dec_cpu];
            KIND_RAW:    rd_sel = raw_q;
            default:     rd_sel = '0;
        endcase

        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.err   = dec_err;
        if (req_valid && !req_write && !dec_err) begin
            rsp_d.data = rd_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.data;

endmodule

// File: rtl/dev_irq_router_chk.sv
module dev_irq_router_chk #(
    parameter int NUM_CPU    = 4,
    parameter int SRC_W      = 64,
    parameter int ADDR_W     = 12,
    parameter int REG_STRIDE = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [1:0]         req_size,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [SRC_W-1:0]   rsp_rdata,
    input logic [SRC_W-1:0]   src_set,
    input logic [SRC_W-1:0]   src_clr,
    input logic [NUM_CPU-1:0] cpu_irq
);

    localparam int IDX_LSB = $clog2(REG_STRIDE);

    logic ro_write;
    assign ro_write = req_valid && req_write &&
                      ((req_addr >> IDX_LSB) >= ADDR_W'(NUM_CPU));

    // R10: one response per request, none without
    p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R10: an errored response carries no data
    p_err_data_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && (rsp_rdata == '0)));
    // R2: narrow accesses are rejected
    p_bad_size_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_size != 2'd3)) |=> rsp_err);
    // R8: writes outside the mask registers are rejected
    p_ro_write_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ro_write |=> rsp_err);
    // R6: an output rises only two edges after a set strobe or a write
    p_irq_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cpu_irq & ~$past(cpu_irq))) |-> $past((|src_set) || (req_valid && req_write), 2));
    // R7: an output falls only two edges after a clear strobe or a write
    p_irq_fall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~cpu_irq & $past(cpu_irq))) |-> $past((|src_clr) || (req_valid && req_write), 2));

endmodule

bind dev_irq_router dev_irq_router_chk #(
    .NUM_CPU    (NUM_CPU),
    .SRC_W      (SRC_W),
    .ADDR_W     (ADDR_W),
    .REG_STRIDE (REG_STRIDE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .src_set   (src_set),
    .src_clr   (src_clr),
    .cpu_irq   (cpu_irq)
);

// File: tb/sim_dev_irq_router.sv
`timescale 1ns/1ps
module sim_dev_irq_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = 2'd3;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_rdata;
    logic [63:0] src_set = '0;
    logic [63:0] src_clr = '0;
    logic [3:0]  cpu_irq;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dev_irq_router u0 (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_size (req_size), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_rdata (rsp_rdata),
        .src_set (src_set), .src_clr (src_clr), .cpu_irq (cpu_irq)
    );

    // behavioural reference model
    logic [63:0] m_mask [4];
    logic [63:0] m_raw;
    logic [3:0]  m_irq;
    logic        e_valid, e_err;
    logic [63:0] e_data;
    logic [63:0] nraw;
    int          midx;
    bit          merr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) m_mask[c] <= '0;
            m_raw <= '0; m_irq <= '0;
            e_valid <= 1'b0; e_err <= 1'b0; e_data <= '0;
        end else begin
            for (int c = 0; c < 4; c++) m_irq[c] <= ((m_mask[c] & m_raw) != 0);
            nraw = m_raw;
            for (int n = 0; n < 64; n++) begin
                if (src_set[n]) nraw[n] = 1'b1;
                else if (src_clr[n]) nraw[n] = 1'b0;
            end
            m_raw <= nraw;
            midx = int'(req_addr) / 64;
            merr = (req_size != 2'd3) || (midx > 8) || (req_write && midx >= 4);
            e_valid <= req_valid;
            e_err   <= req_valid && merr;
            e_data  <= '0;
            if (req_valid && !merr) begin
                if (req_write) m_mask[midx] <= req_wdata;
                else if (midx < 4) e_data <= m_mask[midx];
                else if (midx < 8) e_data <= m_mask[midx-4] & m_raw;
                else e_data <= m_raw;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 cpu_irq vs model", 64'(cpu_irq), 64'(m_irq));
            chk("R10 rsp_valid vs model", 64'(rsp_valid), 64'(e_valid));
            chk("R2 rsp_err vs model", 64'(rsp_err), 64'(e_err));
            chk("R3 rsp_rdata vs model", rsp_rdata, e_data);
        end
    end

    // one register access, entered and left at a falling edge
    task automatic access(input bit wr, input logic [11:0] addr, input logic [1:0] sz,
                          input logic [63:0] wd, output logic [63:0] rd, output logic er);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_size = 2'd3; req_wdata = '0;
        rd = rsp_rdata; er = rsp_err;
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic [63:0] exp);
        logic [63:0] rd; logic er;
        access(1'b0, 12'(idx * 64), 2'd3, '0, rd, er);
        chk(tag, rd, exp);
        chk({tag, " no error"}, 64'(er), 64'd0);
    endtask

    task automatic wr_mask(input int cpu, input logic [63:0] v);
        logic [63:0] rd; logic er;
        access(1'b1, 12'(cpu * 64), 2'd3, v, rd, er);
        chk("R1 mask write accepted", 64'(er), 64'd0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        done = 1'b1;
        summary();
    end

    initial begin
        logic [63:0] rd;
        logic er;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: everything clear after reset
        chk("R9 cpu_irq after reset", 64'(cpu_irq), 64'd0);
        for (int i = 0; i <= 8; i++) rd_chk("R9 register zero after reset", i, 64'd0);

        // R1: masks land at their own index
        wr_mask(0, 64'h0F);
        wr_mask(1, 64'h8000_0000_0000_0000);
        wr_mask(2, '1);
        wr_mask(3, 64'd0);
        rd_chk("R1 mask cpu0", 0, 64'h0F);
        rd_chk("R1 mask cpu1", 1, 64'h8000_0000_0000_0000);
        // R1: offset bits 5:0 ignored
        access(1'b0, 12'(2 * 64 + 8), 2'd3, '0, rd, er);
        chk("R1 low address bits ignored", rd, '1);

        // R4 / R6: raise line 2, check output latency
        src_set = 64'h4;
        @(negedge clk);
        src_set = '0;
        chk("R6 output not yet raised one edge after set", 64'(cpu_irq), 64'd0);
        @(negedge clk);
        chk("R6 output raised for enabling CPUs", 64'(cpu_irq), 64'b0101);
        rd_chk("R4 raw after set", 8, 64'h4);
        rd_chk("R3 routed cpu0", 4, 64'h4);
        rd_chk("R3 routed cpu1", 5, 64'd0);

        // R4: set and clear together on line 10, set wins; line 63 raised
        src_set = 64'h8000_0000_0000_0400;
        src_clr = 64'h0000_0000_0000_0400;
        @(negedge clk);
        src_set = '0; src_clr = '0;
        @(negedge clk);
        chk("R4 line 63 routes to cpu1", 64'(cpu_irq), 64'b0111);
        rd_chk("R4 set beats clear", 8, 64'h8000_0000_0000_0404);

        // R5: spurious clear of line 40
        src_clr = 64'h0000_0100_0000_0000;
        @(negedge clk);
        src_clr = '0;
        rd_chk("R5 spurious clear no effect", 8, 64'h8000_0000_0000_0404);
        // R5: clear line 2 drops cpu0
        src_clr = 64'h4;
        @(negedge clk);
        src_clr = '0;
        @(negedge clk);
        chk("R5 clear drops cpu0", 64'(cpu_irq), 64'b0110);
        rd_chk("R5 raw after clear", 8, 64'h8000_0000_0000_0400);

        // R7: enabling a pending line asserts, removing it deasserts
        wr_mask(3, 64'h400);
        chk("R7 not yet raised right after mask write", 64'(cpu_irq), 64'b0110);
        @(negedge clk);
        chk("R7 mask write asserts cpu3", 64'(cpu_irq), 64'b1110);
        rd_chk("R3 routed cpu3", 7, 64'h400);
        wr_mask(3, 64'd0);
        @(negedge clk);
        chk("R7 mask write deasserts cpu3", 64'(cpu_irq), 64'b0110);

        // R2: narrow accesses rejected
        access(1'b1, 12'(0), 2'd2, '1, rd, er);
        chk("R2 narrow write error", 64'(er), 64'd1);
        rd_chk("R2 mask unchanged after narrow write", 0, 64'h0F);
        access(1'b0, 12'(8 * 64), 2'd0, '0, rd, er);
        chk("R2 narrow read error", 64'(er), 64'd1);
        chk("R2 narrow read data zero", rd, 64'd0);

        // R8: read-only and unmapped writes rejected
        access(1'b1, 12'(5 * 64), 2'd3, 64'd0, rd, er);
        chk("R8 routed write error", 64'(er), 64'd1);
        rd_chk("R8 routed unchanged", 5, 64'h8000_0000_0000_0000);
        access(1'b1, 12'(8 * 64), 2'd3, 64'd0, rd, er);
        chk("R8 raw write error", 64'(er), 64'd1);
        rd_chk("R8 raw unchanged", 8, 64'h8000_0000_0000_0400);
        access(1'b1, 12'(20 * 64), 2'd3, '1, rd, er);
        chk("R8 unmapped write error", 64'(er), 64'd1);
        // R10: unmapped read
        access(1'b0, 12'(9 * 64), 2'd3, '0, rd, er);
        chk("R10 unmapped read error", 64'(er), 64'd1);
        chk("R10 unmapped read zero", rd, 64'd0);
        chk("R6 outputs steady through errors", 64'(cpu_irq), 64'b0110);

        // random traffic, compared every clock by the model
        for (int k = 0; k < 600; k++) begin
            src_set = {$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()};
            src_clr = {$urandom(), $urandom()} & {$urandom(), $urandom()};
            req_valid = ($urandom() % 2) == 0;
            req_write = ($urandom() % 3) == 0;
            req_addr  = 12'((($urandom() % 11) * 64) + ($urandom() % 64));
            req_size  = (($urandom() % 8) == 0) ? 2'(($urandom() % 3)) : 2'd3;
            req_wdata = {$urandom(), $urandom()} & {$urandom(), $urandom()};
            @(negedge clk);
        end
        src_set = '0; src_clr = '0; req_valid = 1'b0; req_write = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        summary();
    end

endmodule